// File: doc/BRIEF.md
# Two-Step Wordline Rail Power Sequencer

This block switches the supply of the wordline driver rails in a memory array cut into row groups of 128 rows each. Every group has a pair of power switches. One connects the driver rail to the main chip supply. The other connects it to a regulated rail. A group that is asleep has both switches open.

A wake request for a group starts a sequence in two ordered steps. First the main-supply switch closes and precharges the rail for a programmable number of cycles. That switch then opens, and in the same cycle the regulated-rail switch closes. After a second programmable settle time, the group's ready flag rises. Only the last part of the rail swing comes from the regulator, which keeps its inrush current low.

A sleep request opens the group's switches at once. The two delay inputs let system software trade rail settling against the sub-100 ns wake budget at the chosen clock frequency. All pins are plain level control and status pins, with one request accepted per cycle for the group on the select input.

Top module: `wl_rail_sequencer`

## Requirements
- R1: After reset, every main-supply enable, regulated-rail enable and ready flag is low.
- R2: A wake request accepted for a group whose switches are all open closes that group's main-supply switch from the next cycle, with its regulated-rail switch still open.
- R3: The main-supply switch of a waking group stays closed for exactly max(pre_cycles,1) cycles. It opens on the same edge that closes the regulated-rail switch, so the two are never closed together.
- R4: The ready flag rises after the regulated-rail switch has been closed alone for exactly max(settle_cycles,1) cycles. While ready is high, the regulated switch is closed and the main-supply switch is open.
- R5: A sleep request for a group opens both of its switches and clears its ready flag on the next edge, from any phase of the sequence.
- R6: When wake and sleep are requested in the same cycle, sleep takes effect and the group ends with all switches open.
- R7: A wake request for a group that is already waking or ready is ignored. The sequence in flight keeps its timing, and ready stays high.
- R8: Requests act only on the group on grp_sel. Every other group keeps its switch and ready state.
- R9: A delay value of 0 behaves as 1 cycle.
- R10: Both delays are captured when a wake is accepted. Changing pre_cycles or settle_cycles during a sequence does not change that sequence's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_sel | input | GRP_W | Group addressed by the requests |
| wake_req | input | 1 | Start waking the selected group |
| sleep_req | input | 1 | Power down the selected group (wins over wake) |
| pre_cycles | input | CNT_W | Main-supply precharge duration in cycles |
| settle_cycles | input | CNT_W | Regulated-rail settle duration in cycles |
| main_sw_en | output | NUM_GROUPS | Per-group main-supply switch enable |
| reg_sw_en | output | NUM_GROUPS | Per-group regulated-rail switch enable |
| rail_ready | output | NUM_GROUPS | Per-group rail-ready flag |

## Verification
Wake sequences are run on different groups with delay pairs that are equal, lopsided, zero and large. Counting the cycles of each phase separates an off-by-one in the precharge counter from one in the settle counter, and shows whether the zero-to-one clamp is present. Sleep requests are issued during precharge, during settle and after ready, and a simultaneous wake and sleep is applied, to show that power-down works from every phase. Repeated wakes, changes to the delay inputs while a sequence runs, and checks on groups that were not selected show that requests are ignored where they should be and that each group's state stays separate.

// File: rtl/wl_rail_pkg.sv
package wl_rail_pkg;
  typedef enum logic [1:0] {
    RAIL_OFF    = 2'd0,
    RAIL_PRECHG = 2'd1,
    RAIL_SETTLE = 2'd2,
    RAIL_ON     = 2'd3
  } rail_state_t;
endpackage

// File: rtl/wl_req_decode.sv
module wl_req_decode #(
  parameter int NUM_GROUPS = 4,
  parameter int GRP_W      = 2
) (
  input  logic [GRP_W-1:0]      grp_sel,
  input  logic                  wake_req,
  input  logic                  sleep_req,
  output logic [NUM_GROUPS-1:0] wake_hit,
  output logic [NUM_GROUPS-1:0] sleep_hit
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    logic sel;
    assign sel          = (grp_sel == GRP_W'(g));
    assign wake_hit[g]  = sel & wake_req;
    assign sleep_hit[g] = sel & sleep_req;
  end
endmodule

// File: rtl/wl_group_seq.sv
module wl_group_seq
  import wl_rail_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_hit,
  input  logic             sleep_hit,
  input  logic [CNT_W-1:0] pre_cycles,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             main_en,
  output logic             reg_en,
  output logic             ready
);
  rail_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pre_lim;
  logic [CNT_W-1:0] set_lim;
  logic [CNT_W-1:0] pre_last;
  logic [CNT_W-1:0] set_last;

  // a zero delay is clamped to one cycle
  assign pre_last = (pre_lim == '0) ? '0 : pre_lim - 1'b1;
  assign set_last = (set_lim == '0) ? '0 : set_lim - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RAIL_OFF;
      cnt     <= '0;
      pre_lim <= '0;
      set_lim <= '0;
    end else if (sleep_hit) begin
      state <= RAIL_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        RAIL_OFF: if (wake_hit) begin
          state   <= RAIL_PRECHG;
          cnt     <= '0;
          pre_lim <= pre_cycles;
          set_lim <= settle_cycles;
        end
        RAIL_PRECHG: begin
          if (cnt == pre_last) begin
            state <= RAIL_SETTLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        RAIL_SETTLE: begin
          if (cnt == set_last) begin
            state <= RAIL_ON;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        RAIL_ON: state <= RAIL_ON;
        default: state <= RAIL_OFF;
      endcase
    end
  end

  assign main_en = (state == RAIL_PRECHG);
  assign reg_en  = (state == RAIL_SETTLE) || (state == RAIL_ON);
  assign ready   = (state == RAIL_ON);

  assert_switch_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_en && reg_en));
  assert_ready_on_regulated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (reg_en && !main_en));
  assert_sleep_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_hit |=> (!main_en && !reg_en && !ready));
  assert_wake_precharge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && !sleep_hit && !main_en && !reg_en) |=> (main_en && !reg_en));
  assert_awake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sleep_hit) |=> ready);
  assert_main_only_from_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> $past(!reg_en));
endmodule

// File: rtl/wl_rail_sequencer.sv
module wl_rail_sequencer #(
  parameter int NUM_GROUPS   = 4,
  parameter int ROWS_PER_GRP = 128,
  parameter int CNT_W        = 8,
  localparam int GRP_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GRP_W-1:0]      grp_sel,
  input  logic                  wake_req,
  input  logic                  sleep_req,
  input  logic [CNT_W-1:0]      pre_cycles,
  input  logic [CNT_W-1:0]      settle_cycles,
  output logic [NUM_GROUPS-1:0] main_sw_en,
  output logic [NUM_GROUPS-1:0] reg_sw_en,
  output logic [NUM_GROUPS-1:0] rail_ready
);
  localparam int TOTAL_ROWS = NUM_GROUPS * ROWS_PER_GRP;

  logic [NUM_GROUPS-1:0] wake_hit;
  logic [NUM_GROUPS-1:0] sleep_hit;

  initial assert (TOTAL_ROWS > 0 && CNT_W > 0) else $error("bad sizing");

  wl_req_decode #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_dec (
    .grp_sel   (grp_sel),
    .wake_req  (wake_req),
    .sleep_req (sleep_req),
    .wake_hit  (wake_hit),
    .sleep_hit (sleep_hit)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    wl_group_seq #(.CNT_W(CNT_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .wake_hit      (wake_hit[g]),
      .sleep_hit     (sleep_hit[g]),
      .pre_cycles    (pre_cycles),
      .settle_cycles (settle_cycles),
      .main_en       (main_sw_en[g]),
      .reg_en        (reg_sw_en[g]),
      .ready         (rail_ready[g])
    );
  end

  assert_groups_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_req && !sleep_req) |=> ($countones(main_sw_en) <= $countones($past(main_sw_en | reg_sw_en))));
endmodule

// File: tb/sim_wl_rail_sequencer.sv
module sim_wl_rail_sequencer;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int GW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [GW-1:0] grp_sel = '0;
  logic wake_req = 0, sleep_req = 0;
  logic [CW-1:0] pre_cycles = 8'd2, settle_cycles = 8'd2;
  logic [N-1:0] main_sw_en, reg_sw_en, rail_ready;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wl_rail_sequencer #(.NUM_GROUPS(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel), .wake_req(wake_req),
    .sleep_req(sleep_req), .pre_cycles(pre_cycles), .settle_cycles(settle_cycles),
    .main_sw_en(main_sw_en), .reg_sw_en(reg_sw_en), .rail_ready(rail_ready));

  // {group, pre, settle, expected pre count, expected settle count}
  localparam logic [39:0] VEC [6] = '{
    {8'd0, 8'd3,  8'd2,  8'd3,  8'd2},
    {8'd1, 8'd1,  8'd1,  8'd1,  8'd1},
    {8'd2, 8'd0,  8'd4,  8'd1,  8'd4},
    {8'd3, 8'd7,  8'd0,  8'd7,  8'd1},
    {8'd0, 8'd0,  8'd0,  8'd1,  8'd1},
    {8'd1, 8'd40, 8'd25, 8'd40, 8'd25}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic req(input int g, input bit w, input bit s);
    @(negedge clk);
    grp_sel = GW'(g); wake_req = w; sleep_req = s;
    @(negedge clk);
    wake_req = 0; sleep_req = 0;
  endtask

  // measure phases from the negedge right after the wake edge
  task automatic measure(input int g, output int pc, output int sc, output int both);
    pc = 0; sc = 0; both = 0;
    while (main_sw_en[g] && pc < 600) begin
      if (reg_sw_en[g]) both++;
      pc++; @(negedge clk);
    end
    while (reg_sw_en[g] && !rail_ready[g] && sc < 600) begin
      sc++; @(negedge clk);
    end
  endtask

  initial begin
    int pc, sc, both;
    repeat (3) @(negedge clk);
    check(main_sw_en == 0 && reg_sw_en == 0 && rail_ready == 0, "R1 reset", int'(main_sw_en | reg_sw_en | rail_ready), 0);
    rst_n = 1;
    @(negedge clk);
    check(main_sw_en == 0 && reg_sw_en == 0 && rail_ready == 0, "R1 after release", int'(main_sw_en | reg_sw_en | rail_ready), 0);

    foreach (VEC[i]) begin
      int g;
      g = int'(VEC[i][39:32]);
      pre_cycles = VEC[i][31:24]; settle_cycles = VEC[i][23:16];
      req(g, 1, 0);
      check(main_sw_en[g] && !reg_sw_en[g], "R2 precharge start", int'(main_sw_en[g]), 1);
      measure(g, pc, sc, both);
      check(pc == int'(VEC[i][15:8]), "R3/R9 precharge length", pc, int'(VEC[i][15:8]));
      check(both == 0, "R3 exclusive switches", both, 0);
      check(sc == int'(VEC[i][7:0]), "R4/R9 settle length", sc, int'(VEC[i][7:0]));
      check(rail_ready[g] && reg_sw_en[g] && !main_sw_en[g], "R4 ready", int'(rail_ready[g]), 1);
      check(rail_ready == (N'(1) << g), "R8 other groups", int'(rail_ready), 1 << g);
      req(g, 0, 1);
      check(!main_sw_en[g] && !reg_sw_en[g] && !rail_ready[g], "R5 sleep from ready", int'(reg_sw_en[g]), 0);
    end

    // R5: sleep during precharge and during settle
    pre_cycles = 8'd5; settle_cycles = 8'd5;
    req(2, 1, 0);
    req(2, 0, 1);
    check(!main_sw_en[2] && !reg_sw_en[2], "R5 sleep in precharge", int'(main_sw_en[2]), 0);
    req(2, 1, 0);
    repeat (6) @(negedge clk);
    check(reg_sw_en[2] && !rail_ready[2], "R5 setup in settle", int'(reg_sw_en[2]), 1);
    req(2, 0, 1);
    check(!reg_sw_en[2] && !rail_ready[2], "R5 sleep in settle", int'(reg_sw_en[2]), 0);

    // R6: wake and sleep together
    req(3, 1, 1);
    check(!main_sw_en[3] && !reg_sw_en[3], "R6 sleep wins", int'(main_sw_en[3]), 0);
    repeat (3) @(negedge clk);
    check(main_sw_en == 0 && reg_sw_en == 0, "R6 stays off", int'(main_sw_en | reg_sw_en), 0);

    // R7: repeated wake during precharge keeps timing; wake on ready ignored
    pre_cycles = 8'd4; settle_cycles = 8'd3;
    req(1, 1, 0);
    req(1, 1, 0);
    measure(1, pc, sc, both);
    check(pc == 2, "R7 rewake no restart", pc, 2);
    check(sc == 3, "R7 settle kept", sc, 3);
    req(1, 1, 0);
    check(rail_ready[1] && !main_sw_en[1], "R7 ready held", int'(rail_ready[1]), 1);
    req(1, 0, 1);

    // R10: change delays mid-sequence
    pre_cycles = 8'd3; settle_cycles = 8'd2;
    req(0, 1, 0);
    pre_cycles = 8'd30; settle_cycles = 8'd30;
    measure(0, pc, sc, both);
    check(pc == 3, "R10 precharge captured", pc, 3);
    check(sc == 2, "R10 settle captured", sc, 2);
    check(rail_ready[1] == 0 && main_sw_en[1] == 0, "R8 group1 untouched", int'(rail_ready[1]), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule